// File: doc/BRIEF.md
# Key-Locked Reset Watchdog Timer

This block is a watchdog timer for a power-management device. A 32-bit down-counter advances on a slow timebase strobe (nominally 32768 Hz). When it runs out, the block can drive a system reset pulse. Software reaches it through a small register window with byte offsets.

The reload, control and reset-enable registers are guarded by a lock. They accept writes only after a 16-bit unlock key has been written to the lock register. Writing any other value to the lock register locks them again.

Software starts the watchdog in three steps:
1. Unlock the window and write the reload value, split into a low half and a high half.
2. Set a control bit that copies the reload value into the counter on the next strobe.
3. Set the run bit and, if wanted, the reset-enable bit.

Two gate registers switch the watchdog on as a whole, and both must be set. When the counter expires with reset enabled, a sticky status field records that the reset came from the watchdog. Only power-on reset clears that field.

Top module: `key_lock_wdog`

## Requirements
- R1: After power-on reset (`por_n` low at a clock edge), the window is locked (lock register bit 0 reads 1). Reload, control, gate, status and counter values all read 0, and `wdog_rst` is low.
- R2: Writing 0xE551 to offset 0x20 unlocks the window, and the lock register bit 0 then reads 0. Writing any other value to offset 0x20, including 0x1AAE, locks it again.
- R3: While the window is locked, writes to reload-low (0x00), reload-high (0x04) and control (0x08) are ignored, and reads keep returning the stored contents.
- R4: Reload-low holds bits 15:0 of the 32-bit reload value and reload-high holds bits 31:16. Both read back what was written.
- R5: The control register at 0x08 has these bits: bit 1 = run, bit 2 = new-load, bit 3 = reset-enable. On the next active strobe, a set new-load bit copies the reload value into the counter and clears itself.
- R6: On each active strobe while run is set and the counter is non-zero, the counter drops by one, borrowing across the two halves. With run clear it holds. The counter reads at 0x30 (bits 15:0) and 0x34 (bits 31:16).
- R7: Strobes are acted on only when bit 2 of module-gate (0x24) and bit 2 of clock-gate (0x28) are both 1; otherwise they have no effect. These two gate registers can be written whether the window is locked or not.
- R8: An active strobe that finds run set, the counter at 0 and no pending new-load is an expiry, and it clears run. With reset-enable set, `wdog_rst` then goes high on the following cycle for exactly RST_CYC clock cycles. So a reload of L expires on the (L+2)-th active strobe after new-load is set.
- R9: An expiry with reset-enable clear clears run but gives no reset pulse and leaves the status field unchanged.
- R10: The status register at 0x2C reads 0x00F0 from the first expiry with reset-enable set onward. It reads 0 before that, and only power-on reset clears it.
- R11: On a strobe where new-load is pending, the load takes priority over both decrement and expiry, even when run is set and the counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Synchronous active-low power-on reset |
| tick | input | 1 | One-cycle timebase strobe (32768 Hz rate) |
| bus_we | input | 1 | Register write enable |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data for `bus_addr` (combinational) |
| wdog_rst | output | 1 | Watchdog reset pulse |

## Verification
The hardest cases to reach are the expiry boundary and the precedence rules at zero. Expiry needs run and reset-enable set and the counter at exactly 0 on a strobe, with no load pending. The bench sweeps small reload values from 0 upward and issues exactly L+1 strobes. It reads the counter and control through the window to confirm the block is sitting at zero. Then one further strobe must start a pulse of exact width. To exercise the load-over-expiry precedence, the bench sets new-load and run together while the counter is already at zero. It drives each case through the unlock key, so the locked-write paths are reached by simply leaving the key unwritten.

// File: rtl/wdog_pkg.sv
// Package: shared offsets, bit positions and types for the key-locked watchdog.
// Assumes a 16-bit register data path and byte offsets on a 6-bit address.
package wdog_pkg;
    localparam int REG_W = 16;
    localparam int ADR_W = 6;

    localparam logic [ADR_W-1:0] OFF_LOAD_LO = 6'h00;
    localparam logic [ADR_W-1:0] OFF_LOAD_HI = 6'h04;
    localparam logic [ADR_W-1:0] OFF_CTRL    = 6'h08;
    localparam logic [ADR_W-1:0] OFF_LOCK    = 6'h20;
    localparam logic [ADR_W-1:0] OFF_MOD_GT  = 6'h24;
    localparam logic [ADR_W-1:0] OFF_CLK_GT  = 6'h28;
    localparam logic [ADR_W-1:0] OFF_STATUS  = 6'h2C;
    localparam logic [ADR_W-1:0] OFF_CNT_LO  = 6'h30;
    localparam logic [ADR_W-1:0] OFF_CNT_HI  = 6'h34;

    localparam int CTL_RUN   = 1;
    localparam int CTL_NEW   = 2;
    localparam int CTL_RSTEN = 3;
    localparam int GATE_BIT  = 2;

    localparam logic [REG_W-1:0] STS_WDOG_FIELD = 16'h00F0;

    typedef struct packed {
        logic rst_en;
        logic newload;
        logic run;
    } wdog_ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
// Module: wdog_regs
// Register window with key lock. Holds the reload value, the control bits and
// the two gate bits, and multiplexes read data. Assumes CNT_W == 2*REG_W and
// that expire_i / load_ack_i are single-cycle pulses from the counter.
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int               CNT_W = 32,
    parameter logic [REG_W-1:0] KEY   = 16'hE551
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             we_i,
    input  logic [ADR_W-1:0] addr_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] rdata_o,
    input  logic             expire_i,
    input  logic             load_ack_i,
    input  logic             status_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [CNT_W-1:0] load_o,
    output wdog_ctrl_t       ctrl_o,
    output logic             active_o
);
    localparam int HI_W = CNT_W - REG_W;

    logic             unlocked_q;
    logic [CNT_W-1:0] load_q;
    wdog_ctrl_t       ctrl_q;
    logic             mod_gt_q;
    logic             clk_gt_q;
    logic             wr_ok;

    assign wr_ok = we_i && unlocked_q;

    // Lock state: key unlocks, any other value written to the lock relocks.
    always_ff @(posedge clk) begin
        if (!por_n) unlocked_q <= 1'b0;
        else if (we_i && addr_i == OFF_LOCK) unlocked_q <= (wdata_i == KEY);
    end

    // Reload halves, written only while unlocked.
    always_ff @(posedge clk) begin
        if (!por_n) load_q <= '0;
        else if (wr_ok && addr_i == OFF_LOAD_LO) load_q[REG_W-1:0] <= wdata_i;
        else if (wr_ok && addr_i == OFF_LOAD_HI) load_q[CNT_W-1:REG_W] <= wdata_i[HI_W-1:0];
    end

    // Control bits: self-clearing new-load, run cleared on expiry, write wins.
    always_ff @(posedge clk) begin
        if (!por_n) ctrl_q <= '0;
        else begin
            if (load_ack_i) ctrl_q.newload <= 1'b0;
            if (expire_i)   ctrl_q.run     <= 1'b0;
            if (wr_ok && addr_i == OFF_CTRL) begin
                ctrl_q.run     <= wdata_i[CTL_RUN];
                ctrl_q.newload <= wdata_i[CTL_NEW];
                ctrl_q.rst_en  <= wdata_i[CTL_RSTEN];
            end
        end
    end

    // Gate bits live outside the lock.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            mod_gt_q <= 1'b0;
            clk_gt_q <= 1'b0;
        end else if (we_i) begin
            if (addr_i == OFF_MOD_GT) mod_gt_q <= wdata_i[GATE_BIT];
            if (addr_i == OFF_CLK_GT) clk_gt_q <= wdata_i[GATE_BIT];
        end
    end

    assign load_o   = load_q;
    assign ctrl_o   = ctrl_q;
    assign active_o = mod_gt_q && clk_gt_q;

    // Read multiplexer over the window.
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            OFF_LOAD_LO: rdata_o = load_q[REG_W-1:0];
            OFF_LOAD_HI: rdata_o[HI_W-1:0] = load_q[CNT_W-1:REG_W];
            OFF_CTRL: begin
                rdata_o[CTL_RUN]   = ctrl_q.run;
                rdata_o[CTL_NEW]   = ctrl_q.newload;
                rdata_o[CTL_RSTEN] = ctrl_q.rst_en;
            end
            OFF_LOCK:    rdata_o[0] = !unlocked_q;
            OFF_MOD_GT:  rdata_o[GATE_BIT] = mod_gt_q;
            OFF_CLK_GT:  rdata_o[GATE_BIT] = clk_gt_q;
            OFF_STATUS:  rdata_o = status_i ? STS_WDOG_FIELD : '0;
            OFF_CNT_LO:  rdata_o = count_i[REG_W-1:0];
            OFF_CNT_HI:  rdata_o[HI_W-1:0] = count_i[CNT_W-1:REG_W];
            default:     rdata_o = '0;
        endcase
    end

    AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        (!unlocked_q && we_i && (addr_i == OFF_LOAD_LO || addr_i == OFF_LOAD_HI))
        |=> $stable(load_q)); // R3
    AST_RELOCK: assert property (@(posedge clk) disable iff (!por_n)
        (we_i && addr_i == OFF_LOCK && wdata_i != KEY) |=> !unlocked_q); // R2
endmodule

// File: rtl/wdog_counter.sv
// Module: wdog_counter
// Down-counter advanced by gated timebase strobes. A pending new-load wins
// over decrement and expiry. Assumes tick_i is high for one clock per period.
module wdog_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             tick_i,
    input  logic             active_i,
    input  logic             run_i,
    input  logic             newload_i,
    input  logic [CNT_W-1:0] load_i,
    output logic [CNT_W-1:0] count_o,
    output logic             load_ack_o,
    output logic             expire_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] count_q;
    logic             step;

    assign step       = tick_i && active_i;
    assign load_ack_o = step && newload_i;
    assign expire_o   = step && !newload_i && run_i && (count_q == '0);
    assign count_o    = count_q;

    // Load on acknowledged new-load, else count down while running.
    always_ff @(posedge clk) begin
        if (!por_n) count_q <= '0;
        else if (load_ack_o) count_q <= load_i;
        else if (step && run_i && count_q != '0) count_q <= count_q - ONE;
    end

    AST_DECREMENT: assert property (@(posedge clk) disable iff (!por_n)
        (step && run_i && !newload_i && count_q != '0)
        |=> (count_q == $past(count_q) - ONE)); // R6
    AST_GATED: assert property (@(posedge clk) disable iff (!por_n)
        !active_i |=> $stable(count_q)); // R7
endmodule

// File: rtl/wdog_rst_gen.sv
// Module: wdog_rst_gen
// Turns an enabled expiry into a fixed-width reset pulse and keeps a sticky
// watchdog-cause flag that only power-on reset clears.
module wdog_rst_gen #(
    parameter int RST_CYC = 16
) (
    input  logic clk,
    input  logic por_n,
    input  logic expire_i,
    input  logic rst_en_i,
    output logic wdog_rst_o,
    output logic status_o
);
    localparam int PW = $clog2(RST_CYC + 1);
    localparam logic [PW-1:0] PULSE_LEN = PW'(RST_CYC);
    localparam logic [PW-1:0] ONE = {{(PW-1){1'b0}}, 1'b1};

    logic [PW-1:0] pulse_q;
    logic          status_q;

    // Pulse length counter.
    always_ff @(posedge clk) begin
        if (!por_n) pulse_q <= '0;
        else if (expire_i && rst_en_i) pulse_q <= PULSE_LEN;
        else if (pulse_q != '0) pulse_q <= pulse_q - ONE;
    end

    // Sticky cause flag.
    always_ff @(posedge clk) begin
        if (!por_n) status_q <= 1'b0;
        else if (expire_i && rst_en_i) status_q <= 1'b1;
    end

    assign wdog_rst_o = (pulse_q != '0);
    assign status_o   = status_q;

    AST_PULSE_START: assert property (@(posedge clk) disable iff (!por_n)
        (expire_i && rst_en_i) |=> (wdog_rst_o && status_o)); // R8
    AST_NO_PULSE: assert property (@(posedge clk) disable iff (!por_n)
        (expire_i && !rst_en_i && !wdog_rst_o) |=> !wdog_rst_o); // R9
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        status_o |=> status_o); // R10
endmodule

// File: rtl/key_lock_wdog.sv
// Module: key_lock_wdog (top)
// Key-locked watchdog: register window, down-counter and reset pulse.
// Assumes a synchronous active-low power-on reset and a one-cycle tick strobe.
module key_lock_wdog
    import wdog_pkg::*;
#(
    parameter int               CNT_W   = 32,
    parameter int               RST_CYC = 16,
    parameter logic [REG_W-1:0] KEY     = 16'hE551
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             tick,
    input  logic             bus_we,
    input  logic [ADR_W-1:0] bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output logic             wdog_rst
);
    logic [CNT_W-1:0] load_w;
    logic [CNT_W-1:0] count_w;
    wdog_ctrl_t       ctrl_w;
    logic             active_w;
    logic             expire_w;
    logic             load_ack_w;
    logic             status_w;

    wdog_regs #(.CNT_W(CNT_W), .KEY(KEY)) u_regs (
        .clk(clk), .por_n(por_n), .we_i(bus_we), .addr_i(bus_addr),
        .wdata_i(bus_wdata), .rdata_o(bus_rdata), .expire_i(expire_w),
        .load_ack_i(load_ack_w), .status_i(status_w), .count_i(count_w),
        .load_o(load_w), .ctrl_o(ctrl_w), .active_o(active_w)
    );

    wdog_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .por_n(por_n), .tick_i(tick), .active_i(active_w),
        .run_i(ctrl_w.run), .newload_i(ctrl_w.newload), .load_i(load_w),
        .count_o(count_w), .load_ack_o(load_ack_w), .expire_o(expire_w)
    );

    wdog_rst_gen #(.RST_CYC(RST_CYC)) u_rst (
        .clk(clk), .por_n(por_n), .expire_i(expire_w),
        .rst_en_i(ctrl_w.rst_en), .wdog_rst_o(wdog_rst), .status_o(status_w)
    );
endmodule

// File: tb/key_lock_wdog_test.sv
// Bench: drives the register window and the tick strobe, and compares what it
// reads back with values worked out from the requirements.
module key_lock_wdog_test;
    localparam int RST_CYC = 16;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        wdog_rst;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    key_lock_wdog #(.CNT_W(32), .RST_CYC(RST_CYC), .KEY(16'hE551)) uut (
        .clk(clk), .por_n(por_n), .tick(tick), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdog_rst(wdog_rst)
    );

    always #4 clk = ~clk;

    // Watchdog for a hung run.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic do_por();
        @(negedge clk);
        por_n = 1'b0;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
    endtask

    task automatic check_reset_state();
        logic [15:0] d;
        rd(6'h20, d); check("R1 lock", {16'h0, d}, 32'h1);
        rd(6'h00, d); check("R1 load lo", {16'h0, d}, 32'h0);
        rd(6'h08, d); check("R1 ctrl", {16'h0, d}, 32'h0);
        rd(6'h24, d); check("R1 module gate", {16'h0, d}, 32'h0);
        rd(6'h2C, d); check("R1 status", {16'h0, d}, 32'h0);
        rd(6'h30, d); check("R1 count lo", {16'h0, d}, 32'h0);
        check("R1 wdog_rst", {31'h0, wdog_rst}, 32'h0);
    endtask

    initial begin
        logic [15:0] d;
        logic [15:0] hi;
        int n;

        do_por();
        check_reset_state();

        // R3: writes ignored while locked
        wr(6'h00, 16'h1234); rd(6'h00, d); check("R3 locked load lo", {16'h0, d}, 32'h0);
        wr(6'h04, 16'h5678); rd(6'h04, d); check("R3 locked load hi", {16'h0, d}, 32'h0);
        wr(6'h08, 16'h000E); rd(6'h08, d); check("R3 locked ctrl", {16'h0, d}, 32'h0);

        // R2 / R4: unlock, load halves, relock with complement and with other value
        wr(6'h20, 16'hE551); rd(6'h20, d); check("R2 unlocked", {16'h0, d}, 32'h0);
        wr(6'h00, 16'hBEEF); wr(6'h04, 16'hCAFE);
        rd(6'h00, d); check("R4 load lo", {16'h0, d}, 32'hBEEF);
        rd(6'h04, d); check("R4 load hi", {16'h0, d}, 32'hCAFE);
        wr(6'h20, 16'h1AAE); rd(6'h20, d); check("R2 relock complement", {16'h0, d}, 32'h1);
        wr(6'h00, 16'h1111); rd(6'h00, d); check("R3 relocked load lo", {16'h0, d}, 32'hBEEF);
        wr(6'h20, 16'hE551); wr(6'h20, 16'h1234);
        rd(6'h20, d); check("R2 relock other", {16'h0, d}, 32'h1);

        // R7: gate registers writable while locked
        wr(6'h24, 16'h0004); rd(6'h24, d); check("R7 gate while locked", {16'h0, d}, 32'h4);
        wr(6'h24, 16'h0000);
        wr(6'h20, 16'hE551);

        // R7 / R5: gate sweep, load only when both gates set
        for (int g = 0; g < 4; g++) begin
            wr(6'h24, (g & 1) ? 16'h0004 : 16'h0000);
            wr(6'h28, (g & 2) ? 16'h0004 : 16'h0000);
            wr(6'h08, 16'h0004);
            pulse_tick();
            rd(6'h30, d); rd(6'h34, hi);
            check($sformatf("R7 gate %0d count", g), {hi, d}, (g == 3) ? 32'hCAFEBEEF : 32'h0);
            rd(6'h08, d);
            check($sformatf("R5 gate %0d newload", g), {16'h0, d}, (g == 3) ? 32'h0 : 32'h4);
        end

        // R6: no run, no count
        pulse_tick();
        rd(6'h30, d); check("R6 hold without run", {16'h0, d}, 32'hBEEF);

        // R6: decrement with run
        wr(6'h08, 16'h0002);
        repeat (3) pulse_tick();
        rd(6'h30, d); rd(6'h34, hi);
        check("R6 three decrements", {hi, d}, 32'hCAFEBEEC);

        // R6: borrow across halves
        wr(6'h00, 16'h0000); wr(6'h04, 16'h0001); wr(6'h08, 16'h0006);
        pulse_tick();
        rd(6'h30, d); rd(6'h34, hi); check("R6 loaded 0x10000", {hi, d}, 32'h00010000);
        pulse_tick();
        rd(6'h30, d); rd(6'h34, hi); check("R6 borrow", {hi, d}, 32'h0000FFFF);

        // R9: expiry without reset enable
        wr(6'h00, 16'h0002); wr(6'h04, 16'h0000); wr(6'h08, 16'h0006);
        repeat (4) pulse_tick();
        n = 0;
        repeat (RST_CYC) begin
            if (wdog_rst) n++;
            @(negedge clk);
        end
        check("R9 no pulse", n, 0);
        rd(6'h08, d); check("R9 run cleared", {16'h0, d}, 32'h0);
        rd(6'h2C, d); check("R9 status unchanged", {16'h0, d}, 32'h0);

        // R11: new-load wins at zero with run set
        wr(6'h00, 16'h0004); wr(6'h08, 16'h000E);
        pulse_tick();
        check("R11 no expiry on load", {31'h0, wdog_rst}, 32'h0);
        rd(6'h30, d); check("R11 loaded", {16'h0, d}, 32'h4);
        wr(6'h08, 16'h0000);

        // R8: expiry sweep over small reload values
        for (int l = 0; l < 6; l++) begin
            wr(6'h00, 16'(l)); wr(6'h08, 16'h000E);
            repeat (l + 1) pulse_tick();
            rd(6'h30, d); check($sformatf("R8 L=%0d at zero", l), {16'h0, d}, 32'h0);
            rd(6'h08, d); check($sformatf("R8 L=%0d armed", l), {16'h0, d}, 32'hA);
            check($sformatf("R8 L=%0d no early pulse", l), {31'h0, wdog_rst}, 32'h0);
            pulse_tick();
            n = 0;
            while (wdog_rst && n < 100) begin
                n++;
                @(negedge clk);
            end
            check($sformatf("R8 L=%0d pulse width", l), n, RST_CYC);
            rd(6'h08, d); check($sformatf("R8 L=%0d run cleared", l), {16'h0, d}, 32'h8);
            rd(6'h2C, d); check($sformatf("R10 L=%0d status", l), {16'h0, d}, 32'h00F0);
        end

        // R10: status holds, then cleared only by power-on reset
        repeat (50) @(negedge clk);
        rd(6'h2C, d); check("R10 status sticky", {16'h0, d}, 32'h00F0);
        do_por();
        rd(6'h2C, d); check("R10 cleared by por", {16'h0, d}, 32'h0);
        check_reset_state();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule